// File: doc/BRIEF.md
# Graphics engine interrupt controller

This block collects event pulses from a 2D/3D drawing engine and holds them in two levels of pending flags. The top level records eight event classes: an invalid-method summary, a context switch, the start of vertical blanking, a coordinate out of range, a missing prerequisite method, an unsupported surface format, a software-clip request and a completed notify. A second level gives the detail behind the invalid-method summary with five fault kinds: an unknown method, a bad parameter value, a notify without the valid flag, a second notify while one is still pending, and a context switch while a notify is pending.

Host software reads and acknowledges the flags over a simple 32-bit register bus with write-one-to-clear semantics. Each level has its own enable mask. The block drives three registered outputs. One line carries vertical blanking alone. A general line carries every other enabled event. A halt output asks the access-control logic to withdraw the engine's FIFO and host access enables while anything is pending, whether it is enabled or not.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, all four registers read zero and irq_gen, irq_vblank and halt are low.
- R2: A pulse on ev_cause[k] sets status bit 4*(k+1) at offset 0x100. Status bit 8 is vertical blanking (ev_cause[1]). Only bits at multiples of 4 exist, status at positions 0..28 and detail at positions 0..16. Every other bit of every register reads zero.
- R3: Writing 1 to a defined bit of the status register (0x100) or the detail register (0x104) clears that bit. Writing 0 leaves the bit unchanged.
- R4: A pulse on ev_fault[k] sets detail bit 4*k at 0x104 and also sets status bit 0.
- R5: Writing 1 to status bit 0 clears the whole detail register.
- R6: A detail write that leaves the detail register at zero clears status bit 0. A partial detail clear leaves status bit 0 set.
- R7: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R8: irq_gen is high when (status AND enable at 0x140, with bit 8 excluded) OR (detail AND detail-enable at 0x144) is non-zero. A disabled event is still recorded in its status register.
- R9: irq_vblank is high exactly when status bit 8 and enable bit 8 are both set. Bit 8 never drives irq_gen.
- R10: halt is high whenever any status bit is set, whatever the enables.
- R11: When host_acc_en is low, writes to 0x140 and 0x144 are ignored, while writes to 0x100 and 0x104 still take effect.
- R12: irq_gen, irq_vblank and halt are registered. Each follows the register state one clock after that state changes, so an event sampled at edge N shows on the lines after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cause | input | 7 | Event pulses for status bits 4, 8, ..., 28 |
| ev_fault | input | 5 | Fault pulses for detail bits 0, 4, ..., 16 |
| host_acc_en | input | 1 | Host access enable from the access-control logic |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_gen | output | 1 | General interrupt line |
| irq_vblank | output | 1 | Vertical blanking interrupt line |
| halt | output | 1 | Any-event-pending halt request |

## Verification
On every cycle the assertions check several invariants. Status bit 0 always mirrors a non-zero detail register. Pending flags raise halt on the next cycle. A fault or cause pulse is never lost. The enables stay frozen while host access is off. Undefined read bits stay zero. Only the bench's scenarios can show the mutual clearing between the two levels, the precedence of an event over a same-cycle clear, and the split routing when only the detail enable is set. They also show that the lines lag the registers by exactly one clock, using a behavioural model compared on every clock.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int TOP_N  = 8;
    localparam int SUB_N  = 5;
    localparam int STRIDE = 4;
    localparam int VB_IDX = 2;

    localparam logic [AW-1:0] ADDR_ST    = 12'h100;
    localparam logic [AW-1:0] ADDR_SUB   = 12'h104;
    localparam logic [AW-1:0] ADDR_EN    = 12'h140;
    localparam logic [AW-1:0] ADDR_SUBEN = 12'h144;

    function automatic logic [DW-1:0] spread(input logic [TOP_N-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < TOP_N; i++) r[i*STRIDE] = v[i];
        return r;
    endfunction

    function automatic logic [TOP_N-1:0] gather(input logic [DW-1:0] w);
        logic [TOP_N-1:0] r;
        for (int i = 0; i < TOP_N; i++) r[i] = w[i*STRIDE];
        return r;
    endfunction
endpackage

// File: rtl/gfx_irq_bank.sv
module gfx_irq_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] st_o
);
    typedef struct packed {
        logic [N-1:0] st;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // set has priority over a same-cycle clear
        bank_d.st = (bank_q.st & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign st_o = bank_q.st;
endmodule

// File: rtl/gfx_irq_lines.sv
module gfx_irq_lines
    import gfx_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOP_N-1:0] top_st,
    input  logic [TOP_N-1:0] top_en,
    input  logic [SUB_N-1:0] sub_st,
    input  logic [SUB_N-1:0] sub_en,
    output logic             irq_gen,
    output logic             irq_vblank,
    output logic             halt
);
    localparam logic [TOP_N-1:0] VB_MASK = TOP_N'(1) << VB_IDX;

    typedef struct packed {
        logic gen;
        logic vb;
        logic halt;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d      = line_q;
        line_d.gen  = (|(top_st & top_en & ~VB_MASK)) | (|(sub_st & sub_en));
        line_d.vb   = top_st[VB_IDX] & top_en[VB_IDX];
        line_d.halt = |top_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign irq_gen    = line_q.gen;
    assign irq_vblank = line_q.vb;
    assign halt       = line_q.halt;
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
    import gfx_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TOP_N-2:0]     ev_cause,
    input  logic [SUB_N-1:0]     ev_fault,
    input  logic                 host_acc_en,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 irq_gen,
    output logic                 irq_vblank,
    output logic                 halt
);
    typedef struct packed {
        logic [TOP_N-1:0] en;
        logic [SUB_N-1:0] suben;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [TOP_N-1:0] top_st, top_set, top_clr, wbits;
    logic [SUB_N-1:0] sub_st, sub_set, sub_clr, wclr_sub;
    logic [TOP_N-1:0] wclr_top;
    logic             wr_st, wr_sub, wr_en, wr_suben, sub_zeroed;

    assign wbits    = gather(bus_wdata);
    assign wr_st    = bus_wr && (bus_addr == ADDR_ST);
    assign wr_sub   = bus_wr && (bus_addr == ADDR_SUB);
    assign wr_en    = bus_wr && (bus_addr == ADDR_EN)    && host_acc_en;
    assign wr_suben = bus_wr && (bus_addr == ADDR_SUBEN) && host_acc_en;

    assign wclr_top = wr_st  ? wbits : '0;
    assign wclr_sub = wr_sub ? wbits[SUB_N-1:0] : '0;

    // detail write that empties the detail register drops the summary
    assign sub_zeroed = wr_sub && (|sub_st) && !(|(sub_st & ~wclr_sub));

    assign sub_set = ev_fault;
    assign sub_clr = wclr_sub | {SUB_N{wclr_top[0]}};
    assign top_set = {ev_cause, |ev_fault};
    assign top_clr = wclr_top | {{(TOP_N-1){1'b0}}, sub_zeroed};

    gfx_irq_bank #(.N(TOP_N)) u_top_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (top_set),
        .clr_i (top_clr),
        .st_o  (top_st)
    );

    gfx_irq_bank #(.N(SUB_N)) u_sub_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sub_set),
        .clr_i (sub_clr),
        .st_o  (sub_st)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en)    cfg_d.en    = wbits;
        if (wr_suben) cfg_d.suben = wbits[SUB_N-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_ST:    bus_rdata = spread(top_st);
            ADDR_SUB:   bus_rdata = spread({{(TOP_N-SUB_N){1'b0}}, sub_st});
            ADDR_EN:    bus_rdata = spread(cfg_q.en);
            ADDR_SUBEN: bus_rdata = spread({{(TOP_N-SUB_N){1'b0}}, cfg_q.suben});
            default:    bus_rdata = '0;
        endcase
    end

    gfx_irq_lines u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .top_st     (top_st),
        .top_en     (cfg_q.en),
        .sub_st     (sub_st),
        .sub_en     (cfg_q.suben),
        .irq_gen    (irq_gen),
        .irq_vblank (irq_vblank),
        .halt       (halt)
    );
endmodule

// File: rtl/gfx_irq_chk.sv
module gfx_irq_chk
    import gfx_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [TOP_N-2:0] ev_cause,
    input logic [SUB_N-1:0] ev_fault,
    input logic             host_acc_en,
    input logic [TOP_N-1:0] top_st,
    input logic [SUB_N-1:0] sub_st,
    input logic [TOP_N-1:0] en_top,
    input logic [DW-1:0]    bus_rdata,
    input logic             irq_vblank,
    input logic             halt
);
    localparam logic [DW-1:0] DEF_MASK = spread('1);

    AST_SUMMARY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        top_st[0] == (|sub_st)); // R6
    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_fault) |=> (top_st[0] && (sub_st != '0))); // R4
    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cause[0] |=> top_st[1]); // R7
    AST_HALT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (top_st != '0) |=> halt); // R10
    AST_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (top_st == '0) |=> !halt); // R10
    AST_VB_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (top_st[VB_IDX] && en_top[VB_IDX]) |=> irq_vblank); // R9
    AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !host_acc_en |=> $stable(en_top)); // R11
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~DEF_MASK) == '0); // R2
endmodule

bind gfx_irq_ctrl gfx_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_cause    (ev_cause),
    .ev_fault    (ev_fault),
    .host_acc_en (host_acc_en),
    .top_st      (top_st),
    .sub_st      (sub_st),
    .en_top      (cfg_q.en),
    .bus_rdata   (bus_rdata),
    .irq_vblank  (irq_vblank),
    .halt        (halt)
);

// File: tb/gfx_irq_ctrl_test.sv
module gfx_irq_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [6:0]  ev_cause = '0;
    logic [4:0]  ev_fault = '0;
    logic        host_acc_en = 1;
    logic        bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_gen, irq_vblank, halt;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gfx_irq_ctrl uut (.*);

    // behavioural reference model
    logic [31:0] m_st = 0, m_sub = 0, m_en = 0, m_suben = 0;
    logic        m_gen = 0, m_vb = 0, m_halt = 0;

    always @(posedge clk) begin
        logic [31:0] nst, nsub;
        if (!rst_n) begin
            m_st = 0; m_sub = 0; m_en = 0; m_suben = 0;
            m_gen = 0; m_vb = 0; m_halt = 0;
        end else begin
            m_gen  = (((m_st & m_en) & ~32'h100) | (m_sub & m_suben)) != 0;
            m_vb   = (m_st & m_en & 32'h100) != 0;
            m_halt = m_st != 0;
            nst = m_st; nsub = m_sub;
            if (bus_wr && bus_addr == 12'h100) begin
                nst = nst & ~(bus_wdata & 32'h11111111);
                if (bus_wdata[0]) nsub = 0;
            end
            if (bus_wr && bus_addr == 12'h104) begin
                nsub = nsub & ~(bus_wdata & 32'h00011111);
                if (m_sub != 0 && nsub == 0) nst[0] = 0;
            end
            for (int k = 0; k < 5; k++) if (ev_fault[k]) begin nsub[4*k] = 1; nst[0] = 1; end
            for (int k = 0; k < 7; k++) if (ev_cause[k]) nst[4*(k+1)] = 1;
            if (bus_wr && host_acc_en && bus_addr == 12'h140) m_en = bus_wdata & 32'h11111111;
            if (bus_wr && host_acc_en && bus_addr == 12'h144) m_suben = bus_wdata & 32'h00011111;
            m_st = nst; m_sub = nsub;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // line outputs compared against the model on every clock (R8 R9 R10 R12)
    always @(negedge clk) if (rst_n && !done) begin
        check("R8 irq_gen", {31'b0, irq_gen}, {31'b0, m_gen});
        check("R9 irq_vblank", {31'b0, irq_vblank}, {31'b0, m_vb});
        check("R10 halt", {31'b0, halt}, {31'b0, m_halt});
    end

    function automatic logic [31:0] m_read(logic [11:0] a);
        case (a)
            12'h100: return m_st;
            12'h104: return m_sub;
            12'h140: return m_en;
            12'h144: return m_suben;
            default: return 0;
        endcase
    endfunction

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, m_read(a));
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic pulse(logic [6:0] c, logic [4:0] f);
        @(negedge clk);
        ev_cause = c; ev_fault = f;
        @(negedge clk);
        ev_cause = 0; ev_fault = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1
        rd(12'h100, 0, "R1 status");
        rd(12'h104, 0, "R1 detail");
        rd(12'h140, 0, "R1 enable");
        rd(12'h144, 0, "R1 detail-enable");
        check("R1 lines", {29'b0, irq_gen, irq_vblank, halt}, 0);
        // R2 every cause, undefined bits zero
        pulse(7'h7F, 0);
        rd(12'h100, 32'h11111110, "R2 all causes");
        rd(12'h0FC, 0, "R2 unmapped");
        // R3 write zero then partial clear
        wr(12'h100, 32'hEEEEEEEE);
        rd(12'h100, 32'h11111110, "R3 write zero");
        wr(12'h100, 32'h11111110);
        rd(12'h100, 0, "R3 clear");
        // R12 lines lag one clock
        @(negedge clk); ev_cause = 7'h01;
        @(negedge clk); ev_cause = 0;
        check("R12 halt not yet", {31'b0, halt}, 0);
        @(negedge clk);
        check("R12 halt next", {31'b0, halt}, 1);
        wr(12'h100, 32'h10);
        // R4 faults
        pulse(0, 5'b10101);
        rd(12'h104, 32'h00010101, "R4 detail");
        rd(12'h100, 32'h1, "R4 summary");
        // R6 partial then full detail clear
        wr(12'h104, 32'h00000101);
        rd(12'h100, 32'h1, "R6 partial keeps");
        wr(12'h104, 32'h00010000);
        rd(12'h100, 0, "R6 full clears");
        // R5 summary clear wipes detail
        pulse(0, 5'b11011);
        wr(12'h100, 32'h1);
        rd(12'h104, 0, "R5 detail wiped");
        // R7 event beats clear
        pulse(7'h40, 0);
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h100; bus_wdata = 32'h10000000; ev_cause = 7'h40;
        @(negedge clk);
        bus_wr = 0; ev_cause = 0;
        rd(12'h100, 32'h10000000, "R7 event wins");
        wr(12'h100, 32'h10000000);
        // R8 masked recorded, then enabled
        pulse(7'h04, 0);
        repeat (2) @(negedge clk);
        check("R8 masked quiet", {31'b0, irq_gen}, 0);
        rd(12'h100, 32'h1000, "R8 masked recorded");
        wr(12'h140, 32'h1000);
        repeat (2) @(negedge clk);
        check("R8 enabled", {31'b0, irq_gen}, 1);
        wr(12'h100, 32'h1000);
        // R8 detail path with summary disabled
        wr(12'h140, 0);
        wr(12'h144, 32'h10);
        pulse(0, 5'b00001);
        repeat (2) @(negedge clk);
        check("R8 detail masked", {31'b0, irq_gen}, 0);
        pulse(0, 5'b00010);
        repeat (2) @(negedge clk);
        check("R8 detail enabled", {31'b0, irq_gen}, 1);
        wr(12'h100, 32'h1);
        // R9 vblank separate line
        wr(12'h140, 32'h11111111);
        pulse(7'h02, 0);
        repeat (2) @(negedge clk);
        check("R9 vblank line", {31'b0, irq_vblank}, 1);
        check("R9 not general", {31'b0, irq_gen}, 0);
        wr(12'h100, 32'h100);
        // R10 halt with everything disabled
        wr(12'h140, 0); wr(12'h144, 0);
        pulse(7'h20, 0);
        repeat (2) @(negedge clk);
        check("R10 halt disabled", {31'b0, halt}, 1);
        // R11 access off
        host_acc_en = 0;
        wr(12'h140, 32'h11111111);
        wr(12'h144, 32'h00011111);
        rd(12'h140, 0, "R11 enable blocked");
        rd(12'h144, 0, "R11 detail-enable blocked");
        wr(12'h100, 32'h01000000);
        rd(12'h100, 0, "R11 status write accepted");
        host_acc_en = 1;
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule